// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block keeps two banks of programmable address-translation windows, one for inbound traffic and one for outbound traffic. Software reaches them through a 32-bit register port. A selector register chooses the direction and the window index, and a group of per-window registers (base, limit, target and two control words) then acts on that one window. Every window holds a staged copy of its settings and a live copy. Only a write to the second control word moves the staged settings into the live copy.

A combinational lookup port takes a direction and a 64-bit address. It searches the live windows of that direction and returns hit or miss, the index of the window that matched, and the translated address. For outbound windows it also returns whether the window is of configuration type, and if so a bus number and a device/function number. A memory window adds the window offset to its target. A configuration window does not add an offset: it takes the bus and device/function numbers from the target and returns the offset into the window as the address.

Top module: `atu_xlate`

## Requirements
- R1: The selector register at offset 0x900 reads back all 32 bits exactly as written. Bits 3:0 choose the window index and bit 31 chooses the direction (1 inbound, 0 outbound).
- R2: The registers of the selected window sit at these offsets: control-1 0x904, control-2 0x908, base low 0x90C, base high 0x910, limit 0x914, target low 0x918, target high 0x91C. Each reads back the staged value of only the selected window.
- R3: Base and target are 64 bits wide. A write to one 32-bit half leaves the other half unchanged. The limit is 32 bits wide.
- R4: After reset every window has base 0, target 0, limit 0xFFFFFFFF, control-1 0 and control-2 0, and the selector reads 0. The one exception is inbound window 0: its control-2 reads 0x80000000 and it is live, so any inbound address up to 0xFFFFFFFF hits it and passes through unchanged.
- R5: Writes to base, limit, target or control-1 do not change any lookup result. A control-2 write commits the window's staged settings together with the value being written. The lookup shows the new settings from the cycle after that write; in the cycle of the write it still shows the old settings.
- R6: A live window hits when base <= address <= limit. Both ends are included, and the limit is zero-extended to 64 bits.
- R7: A memory window returns target + (address - base), modulo 2^64.
- R8: An outbound window whose committed control-1 is nonzero is of configuration type. Its lookup reports the configuration flag, bus = target[31:24] and device/function = target[23:16], and returns address - base as the address. Inbound windows always translate as memory.
- R9: When more than one live window of the chosen direction hits, the lowest index wins, and its index appears on the window-index output.
- R10: On a miss, hit is 0, the translated address equals the input address, and the configuration flag, bus, device/function and index outputs are all 0.
- R11: Offsets outside the selector and window registers read 0, and writes to them change no register and no lookup.
- R12: Bit 31 of control-2 is the window enable. Committing a control-2 value with bit 31 clear removes the window from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| lk_inbound | input | 1 | Lookup direction, 1 inbound, 0 outbound |
| lk_addr | input | 64 | Lookup address |
| lk_hit | output | 1 | A live window matched |
| lk_win | output | 4 | Index of the matching window |
| lk_xaddr | output | 64 | Translated address, or the input address on a miss |
| lk_is_cfg | output | 1 | Matching window is of configuration type |
| lk_bus | output | 8 | Bus number for a configuration hit |
| lk_devfn | output | 8 | Device/function number for a configuration hit |

## Verification
A commit through control-2 and a lookup that touches the same window can arrive in the same cycle. The bench drives both at once on outbound window 0: a control-2 write that disables the window, together with a lookup at that window's base. The lookup is checked before the clock edge, where it must still hit with the old translation, and again after the edge, where it must miss. Staged writes made before each commit are also checked against lookups, to show that they change nothing.

// File: rtl/atu_pkg.sv
package atu_pkg;

    localparam int ATU_REG_AW    = 12;
    localparam int SEL_IDX_W     = 4;
    localparam int SEL_DIR_BIT   = 31;
    localparam int CR2_EN_BIT    = 31;
    localparam int CFG_BUS_LSB   = 24;
    localparam int CFG_DEVFN_LSB = 16;

    localparam logic [ATU_REG_AW-1:0] OFS_SEL     = 12'h900;
    localparam logic [ATU_REG_AW-1:0] OFS_CR1     = 12'h904;
    localparam logic [ATU_REG_AW-1:0] OFS_CR2     = 12'h908;
    localparam logic [ATU_REG_AW-1:0] OFS_BASE_LO = 12'h90C;
    localparam logic [ATU_REG_AW-1:0] OFS_BASE_HI = 12'h910;
    localparam logic [ATU_REG_AW-1:0] OFS_LIMIT   = 12'h914;
    localparam logic [ATU_REG_AW-1:0] OFS_TGT_LO  = 12'h918;
    localparam logic [ATU_REG_AW-1:0] OFS_TGT_HI  = 12'h91C;

    typedef enum logic [3:0] {
        RK_NONE, RK_SEL, RK_CR1, RK_CR2, RK_BASE_LO,
        RK_BASE_HI, RK_LIMIT, RK_TGT_LO, RK_TGT_HI
    } atu_reg_e;

    // Staged (software-visible) settings of one window
    typedef struct packed {
        logic [63:0] base;
        logic [31:0] limit;
        logic [63:0] target;
        logic [31:0] cr1;
        logic [31:0] cr2;
    } atu_shadow_t;

    // Committed decode state used by lookups
    typedef struct packed {
        logic        en;
        logic        is_cfg;
        logic [63:0] base;
        logic [63:0] limit;
        logic [63:0] target;
    } atu_win_t;

    function automatic atu_reg_e atu_decode(input logic [ATU_REG_AW-1:0] a);
        atu_reg_e k;
        case (a)
            OFS_SEL:     k = RK_SEL;
            OFS_CR1:     k = RK_CR1;
            OFS_CR2:     k = RK_CR2;
            OFS_BASE_LO: k = RK_BASE_LO;
            OFS_BASE_HI: k = RK_BASE_HI;
            OFS_LIMIT:   k = RK_LIMIT;
            OFS_TGT_LO:  k = RK_TGT_LO;
            OFS_TGT_HI:  k = RK_TGT_HI;
            default:     k = RK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [31:0] atu_start_cr2(input logic start_en);
        logic [31:0] v;
        v = '0;
        v[CR2_EN_BIT] = start_en;
        return v;
    endfunction

    function automatic atu_shadow_t atu_shadow_reset(input logic start_en);
        atu_shadow_t s;
        s.base   = '0;
        s.limit  = '1;
        s.target = '0;
        s.cr1    = '0;
        s.cr2    = atu_start_cr2(start_en);
        return s;
    endfunction

    function automatic atu_win_t atu_commit(input atu_shadow_t s,
                                            input logic [31:0] cr2,
                                            input logic inbound);
        atu_win_t w;
        w.en     = cr2[CR2_EN_BIT];
        w.is_cfg = !inbound && (s.cr1 != '0);
        w.base   = s.base;
        w.limit  = {32'b0, s.limit};
        w.target = s.target;
        return w;
    endfunction

    function automatic logic [31:0] atu_field(input atu_shadow_t s, input atu_reg_e k);
        logic [31:0] v;
        case (k)
            RK_CR1:     v = s.cr1;
            RK_CR2:     v = s.cr2;
            RK_BASE_LO: v = s.base[31:0];
            RK_BASE_HI: v = s.base[63:32];
            RK_LIMIT:   v = s.limit;
            RK_TGT_LO:  v = s.target[31:0];
            RK_TGT_HI:  v = s.target[63:32];
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/atu_window_regs.sv
module atu_window_regs
    import atu_pkg::*;
#(
    parameter bit INBOUND  = 1'b0,
    parameter bit START_EN = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  atu_reg_e    wr_kind,
    input  logic [31:0] wr_data,
    output atu_shadow_t shadow,
    output atu_win_t    win
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= atu_shadow_reset(START_EN);
            win    <= atu_commit(atu_shadow_reset(START_EN), atu_start_cr2(START_EN), INBOUND);
        end else if (wr_hit) begin
            case (wr_kind)
                RK_CR1:     shadow.cr1          <= wr_data;
                RK_BASE_LO: shadow.base[31:0]   <= wr_data;
                RK_BASE_HI: shadow.base[63:32]  <= wr_data;
                RK_LIMIT:   shadow.limit        <= wr_data;
                RK_TGT_LO:  shadow.target[31:0] <= wr_data;
                RK_TGT_HI:  shadow.target[63:32] <= wr_data;
                RK_CR2: begin
                    shadow.cr2 <= wr_data;
                    win        <= atu_commit(shadow, wr_data, INBOUND);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/atu_window_match.sv
module atu_window_match
    import atu_pkg::*;
(
    input  atu_win_t    win,
    input  logic [63:0] addr,
    output logic        hit,
    output logic [63:0] xaddr
);

    logic [63:0] offset;

    always_comb begin
        offset = addr - win.base;
        hit    = win.en && (addr >= win.base) && (addr <= win.limit);
        xaddr  = win.is_cfg ? offset : (win.target + offset);
    end

endmodule

// File: rtl/atu_pick.sv
module atu_pick
    import atu_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]         hit,
    input  logic [63:0]          xaddr [N],
    input  atu_win_t             win   [N],
    input  logic [63:0]          addr,
    output logic                 lk_hit,
    output logic [SEL_IDX_W-1:0] lk_win,
    output logic [63:0]          lk_xaddr,
    output logic                 lk_is_cfg,
    output logic [7:0]           lk_bus,
    output logic [7:0]           lk_devfn
);

    always_comb begin
        lk_hit    = 1'b0;
        lk_win    = '0;
        lk_xaddr  = addr;
        lk_is_cfg = 1'b0;
        lk_bus    = '0;
        lk_devfn  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                lk_hit    = 1'b1;
                lk_win    = SEL_IDX_W'(i);
                lk_xaddr  = xaddr[i];
                lk_is_cfg = win[i].is_cfg;
                lk_bus    = win[i].is_cfg ? win[i].target[CFG_BUS_LSB +: 8] : 8'h00;
                lk_devfn  = win[i].is_cfg ? win[i].target[CFG_DEVFN_LSB +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/atu_xlate.sv
module atu_xlate
    import atu_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ATU_REG_AW-1:0] wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [ATU_REG_AW-1:0] rd_addr,
    output logic [31:0]           rd_data,
    input  logic                  lk_inbound,
    input  logic [63:0]           lk_addr,
    output logic                  lk_hit,
    output logic [SEL_IDX_W-1:0]  lk_win,
    output logic [63:0]           lk_xaddr,
    output logic                  lk_is_cfg,
    output logic [7:0]            lk_bus,
    output logic [7:0]            lk_devfn
);

    localparam int IDX_W = SEL_IDX_W;

    logic [31:0]       sel_q;
    atu_reg_e          wr_kind;
    atu_reg_e          rd_kind;
    logic              win_wr;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_in;

    atu_shadow_t       sh_in  [NUM_WIN];
    atu_shadow_t       sh_out [NUM_WIN];
    atu_win_t          cw_in  [NUM_WIN];
    atu_win_t          cw_out [NUM_WIN];
    atu_win_t          lk_set [NUM_WIN];
    logic [63:0]       xa_v   [NUM_WIN];
    logic [NUM_WIN-1:0] hit_v;

    assign wr_kind = atu_decode(wr_addr);
    assign rd_kind = atu_decode(rd_addr);
    assign sel_idx = sel_q[IDX_W-1:0];
    assign sel_in  = sel_q[SEL_DIR_BIT];
    assign win_wr  = wr_en && (wr_kind != RK_SEL) && (wr_kind != RK_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en && wr_kind == RK_SEL) begin
            sel_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        atu_window_regs #(.INBOUND(1'b1), .START_EN(g == 0)) u_in (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (win_wr && sel_in && (sel_idx == IDX_W'(g))),
            .wr_kind (wr_kind),
            .wr_data (wr_data),
            .shadow  (sh_in[g]),
            .win     (cw_in[g])
        );
        atu_window_regs #(.INBOUND(1'b0), .START_EN(1'b0)) u_out (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (win_wr && !sel_in && (sel_idx == IDX_W'(g))),
            .wr_kind (wr_kind),
            .wr_data (wr_data),
            .shadow  (sh_out[g]),
            .win     (cw_out[g])
        );
        assign lk_set[g] = lk_inbound ? cw_in[g] : cw_out[g];
        atu_window_match u_match (
            .win   (lk_set[g]),
            .addr  (lk_addr),
            .hit   (hit_v[g]),
            .xaddr (xa_v[g])
        );
    end

    atu_pick #(.N(NUM_WIN)) u_pick (
        .hit       (hit_v),
        .xaddr     (xa_v),
        .win       (lk_set),
        .addr      (lk_addr),
        .lk_hit    (lk_hit),
        .lk_win    (lk_win),
        .lk_xaddr  (lk_xaddr),
        .lk_is_cfg (lk_is_cfg),
        .lk_bus    (lk_bus),
        .lk_devfn  (lk_devfn)
    );

    atu_shadow_t rd_sh;

    always_comb begin
        rd_sh = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                rd_sh = sel_in ? sh_in[i] : sh_out[i];
            end
        end
        case (rd_kind)
            RK_SEL:  rd_data = sel_q;
            RK_NONE: rd_data = '0;
            default: rd_data = atu_field(rd_sh, rd_kind);
        endcase
    end

endmodule

// File: rtl/atu_xlate_chk.sv
module atu_xlate_chk
    import atu_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ATU_REG_AW-1:0] wr_addr,
    input logic [31:0]           wr_data,
    input logic [ATU_REG_AW-1:0] rd_addr,
    input logic [31:0]           rd_data,
    input logic                  lk_inbound,
    input logic [63:0]           lk_addr,
    input logic                  lk_hit,
    input logic [SEL_IDX_W-1:0]  lk_win,
    input logic [63:0]           lk_xaddr,
    input logic                  lk_is_cfg,
    input logic [7:0]            lk_bus,
    input logic [7:0]            lk_devfn
);

    assert_sel_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_SEL) |=> (rd_addr != OFS_SEL || rd_data == $past(wr_data)));

    assert_no_uncommitted_effect_R5: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_addr == OFS_CR2)) ##1 ($stable(lk_addr) && $stable(lk_inbound))
        |-> ($stable(lk_hit) && $stable(lk_xaddr) && $stable(lk_win)));

    assert_cfg_outbound_only_R8: assert property (@(posedge clk) disable iff (rst)
        lk_is_cfg |-> (lk_hit && !lk_inbound));

    assert_miss_passthrough_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_xaddr == lk_addr && !lk_is_cfg && lk_bus == 8'h00
                     && lk_devfn == 8'h00 && lk_win == '0));

endmodule

bind atu_xlate atu_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .lk_inbound (lk_inbound),
    .lk_addr    (lk_addr),
    .lk_hit     (lk_hit),
    .lk_win     (lk_win),
    .lk_xaddr   (lk_xaddr),
    .lk_is_cfg  (lk_is_cfg),
    .lk_bus     (lk_bus),
    .lk_devfn   (lk_devfn)
);

// File: tb/atu_xlate_tb_top.sv
module atu_xlate_tb_top;
    import atu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        lk_inbound = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [3:0]  lk_win;
    logic [63:0] lk_xaddr;
    logic        lk_is_cfg;
    logic [7:0]  lk_bus;
    logic [7:0]  lk_devfn;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    atu_xlate dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lk_inbound(lk_inbound), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_win(lk_win), .lk_xaddr(lk_xaddr), .lk_is_cfg(lk_is_cfg),
        .lk_bus(lk_bus), .lk_devfn(lk_devfn)
    );

    // Bench model, index [dir][win], dir 1 = inbound
    logic [31:0] m_sel;
    logic [63:0] sb_base [2][16];
    logic [63:0] sb_tgt  [2][16];
    logic [31:0] sb_lim  [2][16];
    logic [31:0] sb_cr1  [2][16];
    logic [31:0] sb_cr2  [2][16];
    logic        cm_en   [2][16];
    logic        cm_cfg  [2][16];
    logic [63:0] cm_base [2][16];
    logic [63:0] cm_lim  [2][16];
    logic [63:0] cm_tgt  [2][16];

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] v);
        int d, i;
        d = m_sel[31] ? 1 : 0;
        i = int'(m_sel[3:0]);
        case (a)
            OFS_SEL:     m_sel = v;
            OFS_CR1:     sb_cr1[d][i] = v;
            OFS_BASE_LO: sb_base[d][i][31:0] = v;
            OFS_BASE_HI: sb_base[d][i][63:32] = v;
            OFS_LIMIT:   sb_lim[d][i] = v;
            OFS_TGT_LO:  sb_tgt[d][i][31:0] = v;
            OFS_TGT_HI:  sb_tgt[d][i][63:32] = v;
            OFS_CR2: begin
                sb_cr2[d][i]  = v;
                cm_en[d][i]   = v[31];
                cm_cfg[d][i]  = (d == 0) && (sb_cr1[d][i] != 0);
                cm_base[d][i] = sb_base[d][i];
                cm_lim[d][i]  = {32'b0, sb_lim[d][i]};
                cm_tgt[d][i]  = sb_tgt[d][i];
            end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int d, i;
        d = m_sel[31] ? 1 : 0;
        i = int'(m_sel[3:0]);
        case (a)
            OFS_SEL:     return m_sel;
            OFS_CR1:     return sb_cr1[d][i];
            OFS_CR2:     return sb_cr2[d][i];
            OFS_BASE_LO: return sb_base[d][i][31:0];
            OFS_BASE_HI: return sb_base[d][i][63:32];
            OFS_LIMIT:   return sb_lim[d][i];
            OFS_TGT_LO:  return sb_tgt[d][i][31:0];
            OFS_TGT_HI:  return sb_tgt[d][i][63:32];
            default:     return 32'h0;
        endcase
    endfunction

    function automatic logic [85:0] exp_lk(input int d, input logic [63:0] a);
        logic [63:0] off;
        for (int i = 0; i < 16; i++) begin
            if (cm_en[d][i] && a >= cm_base[d][i] && a <= cm_lim[d][i]) begin
                off = a - cm_base[d][i];
                return {1'b1, 4'(i), cm_cfg[d][i] ? off : cm_tgt[d][i] + off, cm_cfg[d][i],
                        cm_cfg[d][i] ? cm_tgt[d][i][31:24] : 8'h00,
                        cm_cfg[d][i] ? cm_tgt[d][i][23:16] : 8'h00};
            end
        end
        return {1'b0, 4'h0, a, 1'b0, 16'h0};
    endfunction

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, v);
    endtask

    task automatic reg_rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, {96'b0, rd_data}, {96'b0, model_read(a)});
    endtask

    task automatic lk_now(input int d, input logic [63:0] a, input string tag);
        lk_inbound = (d == 1);
        lk_addr = a;
        #1;
        check(tag, {42'b0, lk_hit, lk_win, lk_xaddr, lk_is_cfg, lk_bus, lk_devfn},
              {42'b0, exp_lk(d, a)});
    endtask

    task automatic lk_chk(input int d, input logic [63:0] a, input string tag);
        @(negedge clk);
        lk_now(d, a, tag);
    endtask

    function automatic logic [31:0] wbase(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0010_0000;
    endfunction

    initial begin
        m_sel = '0;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 16; i++) begin
                sb_base[d][i] = '0; sb_tgt[d][i] = '0; sb_lim[d][i] = 32'hFFFF_FFFF;
                sb_cr1[d][i] = '0;
                sb_cr2[d][i] = (d == 1 && i == 0) ? 32'h8000_0000 : 32'h0;
                cm_en[d][i] = (d == 1 && i == 0);
                cm_cfg[d][i] = 1'b0; cm_base[d][i] = '0;
                cm_lim[d][i] = 64'hFFFF_FFFF; cm_tgt[d][i] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: reset contents and reset lookups
        reg_rd(OFS_SEL, "R4 selector");
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 16; i++) begin
                reg_wr(OFS_SEL, {d[0], 27'b0, 4'(i)});
                reg_rd(OFS_CR1, "R4 cr1");
                reg_rd(OFS_CR2, "R4 cr2");
                reg_rd(OFS_BASE_LO, "R4 base lo");
                reg_rd(OFS_BASE_HI, "R4 base hi");
                reg_rd(OFS_LIMIT, "R4 limit");
                reg_rd(OFS_TGT_LO, "R4 tgt lo");
                reg_rd(OFS_TGT_HI, "R4 tgt hi");
            end
        end
        lk_chk(1, 64'h0, "R4 inbound low");
        lk_chk(1, 64'hFFFF_FFFF, "R4 R6 inbound top");
        lk_chk(1, 64'h1_0000_0000, "R4 R10 inbound above");
        lk_chk(0, 64'h1234, "R4 R10 outbound");

        // R1: selector readback
        reg_wr(OFS_SEL, 32'h7ABC_0003);
        reg_rd(OFS_SEL, "R1 readback");
        reg_wr(OFS_SEL, 32'h8000_000F);
        reg_rd(OFS_SEL, "R1 readback dir");

        // R11: unmapped offsets
        reg_wr(12'h800, 32'hFFFF_FFFF);
        reg_wr(12'h920, 32'h8000_0000);
        reg_rd(12'h800, "R11 unmapped");
        reg_rd(12'h920, "R11 unmapped");
        lk_chk(1, 64'h10, "R11 lookup unchanged");
        lk_chk(0, 64'h10, "R11 lookup unchanged");

        // Program every window
        for (int d = 1; d >= 0; d--) begin
            for (int i = 0; i < 16; i++) begin
                logic [31:0] b;
                b = wbase(i);
                reg_wr(OFS_SEL, {d[0], 27'b0, 4'(i)});
                reg_wr(OFS_BASE_HI, 32'hFFFF_FFFF);
                reg_wr(OFS_BASE_LO, b);
                reg_wr(OFS_BASE_HI, 32'h0);
                reg_rd(OFS_BASE_LO, "R3 base lo kept");
                reg_rd(OFS_BASE_HI, "R3 base hi");
                reg_wr(OFS_TGT_LO, 32'h4000_0000 + (32'(i) << 16) + (32'(d) << 8));
                reg_wr(OFS_TGT_HI, 32'hA0 + 32'(i));
                reg_rd(OFS_TGT_LO, "R3 tgt lo");
                reg_rd(OFS_TGT_HI, "R3 tgt hi");
                reg_wr(OFS_LIMIT, b + 32'h001F_FFFF);
                reg_wr(OFS_CR1, (i % 2 == 1) ? ((d == 0) ? 32'h4 : 32'h7) : 32'h0);
                lk_chk(d, {32'b0, b}, "R5 staged no effect");
                reg_wr(OFS_CR2, (i == 5) ? 32'h0 : 32'h8000_0000);
                reg_rd(OFS_CR2, "R2 cr2");
                lk_chk(d, {32'b0, b}, "R5 R7 committed");
            end
        end

        // R2: windows independent
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 16; i++) begin
                reg_wr(OFS_SEL, {d[0], 27'b0, 4'(i)});
                reg_rd(OFS_LIMIT, "R2 limit per window");
                reg_rd(OFS_TGT_LO, "R2 tgt per window");
                reg_rd(OFS_CR1, "R2 cr1 per window");
            end
        end

        // Boundary sweep
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 16; i++) begin
                logic [63:0] b;
                b = {32'b0, wbase(i)};
                lk_chk(d, b - 1, "R6 R9 below base");
                lk_chk(d, b, "R6 R7 R9 base");
                lk_chk(d, b + 1, "R7 R9");
                lk_chk(d, b + 64'h000F_FFFF, "R8 R9");
                lk_chk(d, b + 64'h0010_0000, "R8 R9 upper half");
                lk_chk(d, b + 64'h001F_FFFF, "R6 R8 at limit");
                lk_chk(d, b + 64'h0020_0000, "R6 R10 above limit");
            end
        end
        lk_chk(0, 64'hFFFF_FFFF_0000_0000, "R10 high address");
        lk_chk(1, 64'h0000_0001_1000_0000, "R10 high address");

        // Commit and lookup in the same cycle on outbound window 0
        reg_wr(OFS_SEL, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = OFS_CR2; wr_data = 32'h0;
        lk_now(0, {32'b0, wbase(0)}, "R5 same-cycle old state");
        check("R5 same-cycle still hits", {127'b0, lk_hit}, 128'd1);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(OFS_CR2, 32'h0);
        lk_now(0, {32'b0, wbase(0)}, "R12 disabled window");
        check("R12 miss after disable", {127'b0, lk_hit}, 128'd0);
        reg_wr(OFS_CR2, 32'h8000_0000);
        lk_chk(0, {32'b0, wbase(0)}, "R12 re-enabled");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule